// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is the byte-level half of a serial configuration slave. A bit-level I2C/SMBus engine in front of it detects start and stop conditions, shifts bytes in and out, and passes each event here as a one-cycle pulse. The block decides which bytes to acknowledge and which byte to send next. It keeps a bank of 21 eight-bit configuration registers, which the rest of the chip reads through a flat output bus.

Only two transfer shapes exist, and both begin at register 0. In a block write, the host sends the write address and then two header bytes, which are acknowledged and dropped. The data bytes that follow fill registers 0, 1, 2 and onward. In a block read, the block first returns a byte count taken from the length register, then returns the registers from 0 upward.

Some registers have special rules:
- Two register pairs change only when both halves arrive in the same transfer. The new values land when the stop condition arrives.
- One register is locked against host writes.
- An identification register is read-only.
- The length register refuses a zero.

Top module: `cfgbus_blkreg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `DEV_ADDR` (default 7'h69, giving D2h for write and D3h for read) is acknowledged. Any other address byte is not acknowledged, and the bytes that follow it up to the next start are neither acknowledged nor stored.
- R2: In a write, the two bytes that follow the address are acknowledged and their values are discarded. The first byte after them lands in register 0.
- R3: Each data byte of a write is acknowledged, with `ack_valid_o` high one cycle after `rx_valid_i`. Data bytes fill registers in ascending order. A plain register shows its new value on `cfg_o[8*i +: 8]` one cycle after its byte. A stop after any complete byte ends the transfer and keeps the bytes already stored.
- R4: In a read, the first byte returned is the value of register 8, followed by register 0, register 1 and so on. Each byte appears on `tx_byte_o` with `tx_valid_o` one cycle after `tx_req_i`.
- R5: Register 8 resets to 08h. A write of 00h to it leaves its value unchanged, and any non-zero value is stored.
- R6: Registers 11 and 12 form a pair, and so do registers 13 and 14. Writes to these registers are held in staging storage. The live values change only on the cycle after a stop, and only when both registers of the pair were written since the last start. Otherwise neither register of the pair changes.
- R7: Register 6 always reads `LOCK_VAL` (default 06h), whatever the host writes to it.
- R8: Register 7 always reads 001 in bits 7:5 and `REV_ID` (default 05h) in bits 4:0, so 25h by default. Host writes do not change it.
- R9: Registers 19 and 20 store whatever is written to them and reset to 00h.
- R10: Data bytes beyond register 20 are acknowledged and discarded. A read that passes register 20 keeps returning register 20.
- R11: After reset, both `ack_valid_o` and `tx_valid_o` are low. Register 8 reads 08h, register 9 reads 10h, and registers 0 to 5, 10 to 20 read 00h.
- R12: Once the host answers a read byte with a not-acknowledge, every further byte request until the next start returns FFh. A byte request outside a read also returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_start_i | input | 1 | Start or repeated start seen, one-cycle pulse |
| ev_stop_i | input | 1 | Stop seen, one-cycle pulse |
| rx_valid_i | input | 1 | A byte was received from the host |
| rx_byte_i | input | 8 | The received byte |
| ack_valid_o | output | 1 | Acknowledge decision valid for the last received byte |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_req_i | input | 1 | Engine asks for the next byte to transmit |
| tx_valid_o | output | 1 | `tx_byte_o` holds the answer to the last request |
| tx_byte_o | output | 8 | Byte to transmit |
| mack_valid_i | input | 1 | The host's acknowledge bit for a transmitted byte is valid |
| mack_i | input | 1 | Host acknowledge, 1 = ack, 0 = not-acknowledge |
| cfg_o | output | 168 | Live register bank, register i at bits 8*i+7 down to 8*i |

## Verification
The assertions assume that the engine raises at most one of start, stop, byte received, byte request or host acknowledge in any cycle. They also assume that every event is a single-cycle pulse. The bench drives each event for exactly one cycle on a falling edge and returns all inputs to idle before the next event, so this assumption always holds. The bench issues byte requests only after a read address, or deliberately while idle to check the FFh filler. It answers every transmitted byte with a host acknowledge before it sends the next request.

// File: rtl/cbr_pkg.sv
// Shared constants, phase encoding and reset values for the block-write
// configuration slave. Assumes a bank of 21 byte-wide registers.
package cbr_pkg;
    localparam int NREG     = 21;
    localparam int BW       = 8;
    localparam int IDXW     = $clog2(NREG + 1);
    localparam int IX_LOCK  = 6;
    localparam int IX_ID    = 7;
    localparam int IX_LEN   = 8;
    localparam int IX_WDOG  = 9;
    localparam int IX_PAIR0 = 11;    // pairs occupy IX_PAIR0 .. IX_PAIR0+NPAIRREG-1
    localparam int NPAIRREG = 4;
    localparam logic [2:0] VENDOR_ID = 3'b001;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_HDR0, PH_HDR1, PH_WDATA, PH_RDATA, PH_SKIP
    } phase_t;

    // Power-on value of a writable register.
    function automatic logic [BW-1:0] rst_val(input int idx);
        case (idx)
            IX_LEN:  return 8'h08;
            IX_WDOG: return 8'h10;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/cbr_seq.sv
// Transaction sequencer: tracks the phase of the current transfer from the
// engine's events, decides acknowledges, produces write strobes and walks
// the read pointer. Assumes at most one event per cycle from the engine.
module cbr_seq
    import cbr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_start_i,
    input  logic            ev_stop_i,
    input  logic            rx_valid_i,
    input  logic [BW-1:0]   rx_byte_i,
    input  logic            tx_req_i,
    input  logic            mack_valid_i,
    input  logic            mack_i,
    input  logic [BW-1:0]   rd_byte_i,
    output logic            ack_valid_o,
    output logic            ack_o,
    output logic            tx_valid_o,
    output logic [BW-1:0]   tx_byte_o,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic            rd_first_o,
    output logic [IDXW-1:0] rd_idx_o
);
    localparam logic [IDXW-1:0] WR_END  = IDXW'(NREG);
    localparam logic [IDXW-1:0] RD_LAST = IDXW'(NREG - 1);

    phase_t phase_q;

    // Write strobe for the current data byte while the pointer is in the bank.
    assign wr_en_o = rx_valid_i && !ev_start_i && !ev_stop_i &&
                     (phase_q == PH_WDATA) && (wr_idx_o != WR_END);

    // Phase, pointer, acknowledge and transmit-byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            ack_valid_o <= 1'b0;
            ack_o       <= 1'b0;
            tx_valid_o  <= 1'b0;
            tx_byte_o   <= '1;
            wr_idx_o    <= '0;
            rd_first_o  <= 1'b0;
            rd_idx_o    <= '0;
        end else begin
            ack_valid_o <= 1'b0;
            tx_valid_o  <= 1'b0;
            if (ev_start_i) begin
                phase_q <= PH_ADDR;
            end else if (ev_stop_i) begin
                phase_q <= PH_IDLE;
            end else if (rx_valid_i) begin
                ack_valid_o <= 1'b1;
                ack_o       <= 1'b0;
                case (phase_q)
                    PH_ADDR: begin
                        if (rx_byte_i[7:1] == DEV_ADDR) begin
                            ack_o <= 1'b1;
                            if (rx_byte_i[0]) begin
                                phase_q    <= PH_RDATA;
                                rd_first_o <= 1'b1;
                                rd_idx_o   <= '0;
                            end else begin
                                phase_q <= PH_HDR0;
                            end
                        end else begin
                            phase_q <= PH_SKIP;
                        end
                    end
                    PH_HDR0: begin
                        ack_o   <= 1'b1;
                        phase_q <= PH_HDR1;
                    end
                    PH_HDR1: begin
                        ack_o    <= 1'b1;
                        phase_q  <= PH_WDATA;
                        wr_idx_o <= '0;
                    end
                    PH_WDATA: begin
                        ack_o <= 1'b1;
                        if (wr_idx_o != WR_END) wr_idx_o <= wr_idx_o + 1'b1;
                    end
                    default: ack_o <= 1'b0;
                endcase
            end else if (tx_req_i) begin
                tx_valid_o <= 1'b1;
                if (phase_q == PH_RDATA) begin
                    tx_byte_o <= rd_byte_i;
                    if (rd_first_o)                rd_first_o <= 1'b0;
                    else if (rd_idx_o != RD_LAST)  rd_idx_o   <= rd_idx_o + 1'b1;
                end else begin
                    tx_byte_o <= '1;
                end
            end else if (mack_valid_i && !mack_i && phase_q == PH_RDATA) begin
                phase_q <= PH_SKIP;
            end
        end
    end
endmodule

// File: rtl/cbr_bank.sv
// Register bank: plain, locked, read-only, non-zero-only and paired
// registers. Paired writes are staged and committed on stop when both
// halves of a pair were written since the last start.
module cbr_bank
    import cbr_pkg::*;
#(
    parameter logic [4:0]    REV_ID   = 5'h05,
    parameter logic [BW-1:0] LOCK_VAL = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDXW-1:0]   wr_idx_i,
    input  logic [BW-1:0]     wr_data_i,
    input  logic              stage_clr_i,
    input  logic              commit_i,
    output logic [NREG*BW-1:0] bank_o
);
    logic [NPAIRREG-1:0] seen;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [IDXW-1:0] MYIDX = IDXW'(g);
        if (g == IX_LOCK) begin : g_lock
            assign bank_o[g*BW +: BW] = LOCK_VAL;
        end else if (g == IX_ID) begin : g_id
            assign bank_o[g*BW +: BW] = {VENDOR_ID, REV_ID};
        end else if (g == IX_LEN) begin : g_len
            logic [BW-1:0] q;
            // Length register: keep old value when a zero is written.
            always_ff @(posedge clk) begin
                if (!rst_n)                                         q <= rst_val(g);
                else if (wr_en_i && wr_idx_i == MYIDX && wr_data_i != '0) q <= wr_data_i;
            end
            assign bank_o[g*BW +: BW] = q;
        end else if (g >= IX_PAIR0 && g < IX_PAIR0 + NPAIRREG) begin : g_pair
            localparam int SLOT = g - IX_PAIR0;
            localparam int MATE = SLOT ^ 1;
            logic [BW-1:0] live_q, shad_q;
            logic          seen_q;
            // Paired register: stage on write, commit on stop when both seen.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q <= rst_val(g);
                    shad_q <= '0;
                    seen_q <= 1'b0;
                end else if (stage_clr_i) begin
                    seen_q <= 1'b0;
                end else if (commit_i) begin
                    seen_q <= 1'b0;
                    if (seen_q && seen[MATE]) live_q <= shad_q;
                end else if (wr_en_i && wr_idx_i == MYIDX) begin
                    shad_q <= wr_data_i;
                    seen_q <= 1'b1;
                end
            end
            assign seen[SLOT]          = seen_q;
            assign bank_o[g*BW +: BW]  = live_q;
        end else begin : g_plain
            logic [BW-1:0] q;
            // Plain register: take every write addressed to it.
            always_ff @(posedge clk) begin
                if (!rst_n)                             q <= rst_val(g);
                else if (wr_en_i && wr_idx_i == MYIDX)  q <= wr_data_i;
            end
            assign bank_o[g*BW +: BW] = q;
        end
    end
endmodule

// File: rtl/cbr_rdsel.sv
// Read-data select: the count byte first, then the register at the read
// pointer. Assumes the pointer never exceeds the last register.
module cbr_rdsel
    import cbr_pkg::*;
(
    input  logic [NREG*BW-1:0] bank_i,
    input  logic               first_i,
    input  logic [IDXW-1:0]    idx_i,
    output logic [BW-1:0]      byte_o
);
    // Pick count or indexed register.
    always_comb begin
        if (first_i) byte_o = bank_i[IX_LEN*BW +: BW];
        else         byte_o = bank_i[int'(idx_i)*BW +: BW];
    end
endmodule

// File: rtl/cfgbus_blkreg_slave.sv
// Top of the block-write configuration slave. Sits behind a bit-level
// serial engine; assumes one-cycle event pulses, at most one per cycle.
module cfgbus_blkreg_slave
    import cbr_pkg::*;
#(
    parameter logic [6:0]    DEV_ADDR = 7'h69,
    parameter logic [4:0]    REV_ID   = 5'h05,
    parameter logic [BW-1:0] LOCK_VAL = 8'h06
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_start_i,
    input  logic               ev_stop_i,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_byte_i,
    output logic               ack_valid_o,
    output logic               ack_o,
    input  logic               tx_req_i,
    output logic               tx_valid_o,
    output logic [7:0]         tx_byte_o,
    input  logic               mack_valid_i,
    input  logic               mack_i,
    output logic [NREG*BW-1:0] cfg_o
);
    logic            wr_en, rd_first;
    logic [IDXW-1:0] wr_idx, rd_idx;
    logic [BW-1:0]   rd_byte;

    cbr_seq #(.DEV_ADDR(DEV_ADDR)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .ev_start_i(ev_start_i), .ev_stop_i(ev_stop_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .tx_req_i(tx_req_i), .mack_valid_i(mack_valid_i), .mack_i(mack_i),
        .rd_byte_i(rd_byte),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .rd_first_o(rd_first), .rd_idx_o(rd_idx)
    );

    cbr_bank #(.REV_ID(REV_ID), .LOCK_VAL(LOCK_VAL)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(rx_byte_i),
        .stage_clr_i(ev_start_i), .commit_i(ev_stop_i),
        .bank_o(cfg_o)
    );

    cbr_rdsel rdsel_i (
        .bank_i(cfg_o), .first_i(rd_first), .idx_i(rd_idx), .byte_o(rd_byte)
    );
endmodule

// File: rtl/cfgbus_blkreg_chk.sv
// Protocol and register-rule checker, bound to the top module.
module cfgbus_blkreg_chk
    import cbr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ev_start_i,
    input logic               ev_stop_i,
    input logic               rx_valid_i,
    input logic               tx_req_i,
    input logic               ack_valid_o,
    input logic               tx_valid_o,
    input logic [NREG*BW-1:0] cfg_o
);
    // R3
    ack_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !ev_start_i && !ev_stop_i) |=> ack_valid_o);
    // R4
    tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && !rx_valid_i && !ev_start_i && !ev_stop_i) |=> tx_valid_o);
    // R5
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[IX_LEN*BW +: BW] != '0);
    // R8
    vendor_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[IX_ID*BW+5 +: 3] == VENDOR_ID);
    // R7
    lock_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_o[IX_LOCK*BW +: BW]));
    // R6
    pair_a_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o[IX_PAIR0*BW +: 2*BW]) |-> $past(ev_stop_i));
    // R6
    pair_b_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o[(IX_PAIR0+2)*BW +: 2*BW]) |-> $past(ev_stop_i));
endmodule

bind cfgbus_blkreg_slave cfgbus_blkreg_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ev_start_i(ev_start_i), .ev_stop_i(ev_stop_i),
    .rx_valid_i(rx_valid_i), .tx_req_i(tx_req_i), .ack_valid_o(ack_valid_o),
    .tx_valid_o(tx_valid_o), .cfg_o(cfg_o)
);

// File: tb/cfgbus_blkreg_slave_tb_top.sv
module cfgbus_blkreg_slave_tb_top;
    localparam int NR = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, rx_valid = 0, tx_req = 0, mack_valid = 0, mack = 0;
    logic [7:0] rx_byte = '0;
    logic ack_valid_o, ack_o, tx_valid_o;
    logic [7:0] tx_byte_o;
    logic [NR*8-1:0] cfg_o;

    int n_chk = 0, n_bad = 0;
    logic [7:0] wbuf [24];
    logic [7:0] model [NR];

    // {write value, expected live value} for registers 0..20
    localparam logic [15:0] VEC [NR] = '{
        16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'hFF06,
        16'h0025, 16'h1515, 16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD,
        16'hEEEE, 16'hF1F1, 16'hF2F2, 16'hF3F3, 16'hF4F4, 16'h5A5A, 16'hA5A5};

    always #4 clk = ~clk;

    cfgbus_blkreg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .ev_start_i(ev_start), .ev_stop_i(ev_stop),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .ack_valid_o(ack_valid_o),
        .ack_o(ack_o), .tx_req_i(tx_req), .tx_valid_o(tx_valid_o),
        .tx_byte_o(tx_byte_o), .mack_valid_i(mack_valid), .mack_i(mack),
        .cfg_o(cfg_o));

    function automatic logic [7:0] regv(input int i);
        return cfg_o[i*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        ev_start = 1; @(negedge clk); ev_start = 0;
    endtask
    task automatic do_stop();
        ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask
    task automatic put_byte(input logic [7:0] b, input bit exp_ack, input string req);
        rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0;
        chk(ack_valid_o && ack_o == exp_ack, req, {ack_valid_o, ack_o}, {1'b1, exp_ack});
    endtask
    task automatic get_byte(input logic [7:0] exp, input bit host_ack, input string req);
        tx_req = 1; @(negedge clk); tx_req = 0;
        chk(tx_valid_o && tx_byte_o == exp, req, tx_byte_o, exp);
        mack_valid = 1; mack = host_ack; @(negedge clk); mack_valid = 0;
    endtask
    task automatic write_txn(input int n, input logic [7:0] cmd, input logic [7:0] cnt,
                             input bit finish);
        do_start();
        put_byte(8'hD2, 1, "R1 write address");
        put_byte(cmd, 1, "R2 command byte");
        put_byte(cnt, 1, "R2 count byte");
        for (int i = 0; i < n; i++) put_byte(wbuf[i], 1, "R3/R10 data byte");
        if (finish) do_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!ack_valid_o && !tx_valid_o, "R11 idle outputs", {ack_valid_o, tx_valid_o}, 0);
        chk(regv(8) == 8'h08, "R5 R11 length reset", regv(8), 8'h08);
        chk(regv(9) == 8'h10, "R11 reg9 reset", regv(9), 8'h10);
        chk(regv(0) == 8'h00 && regv(12) == 8'h00, "R11 reg0/12 reset", regv(0), 0);
        chk(regv(19) == 8'h00 && regv(20) == 8'h00, "R9 reset", regv(20), 0);
        chk(regv(6) == 8'h06, "R7 lock reset", regv(6), 8'h06);
        chk(regv(7) == 8'h25, "R8 id reset", regv(7), 8'h25);

        // Table walk: full block write plus two bytes past the bank (R10)
        for (int i = 0; i < NR; i++) begin
            wbuf[i]  = VEC[i][15:8];
            model[i] = VEC[i][7:0];
        end
        wbuf[21] = 8'h77; wbuf[22] = 8'h78; wbuf[23] = 8'h79;
        write_txn(23, 8'h00, 8'h15, 1);
        for (int i = 0; i < NR; i++)
            chk(regv(i) == model[i], $sformatf("R3 R6 R7 R8 R9 reg%0d", i), regv(i), model[i]);

        // R2 header bytes dropped, R3 stop after first data byte
        wbuf[0] = 8'h42;
        write_txn(1, 8'h5E, 8'h03, 1);
        chk(regv(0) == 8'h42, "R2 first data to reg0", regv(0), 8'h42);
        chk(regv(1) == 8'h22, "R3 early stop keeps reg1", regv(1), 8'h22);
        wbuf[0] = VEC[0][15:8];

        // R5 zero to length register ignored
        wbuf[8] = 8'h00;
        write_txn(9, 8'h00, 8'h00, 1);
        chk(regv(8) == 8'h15, "R5 zero length ignored", regv(8), 8'h15);
        chk(regv(0) == 8'h11, "R3 reg0 rewritten", regv(0), 8'h11);
        wbuf[8] = 8'h15;

        // R6 half a pair loads nothing
        wbuf[11] = 8'h01;
        write_txn(12, 8'h00, 8'h00, 1);
        chk(regv(11) == 8'hBB, "R6 lone low half", regv(11), 8'hBB);
        wbuf[11] = 8'h31; wbuf[12] = 8'h32; wbuf[13] = 8'h33;
        write_txn(14, 8'h00, 8'h00, 1);
        chk(regv(11) == 8'h31 && regv(12) == 8'h32, "R6 full pair", regv(12), 8'h32);
        chk(regv(13) == 8'hDD, "R6 second pair half", regv(13), 8'hDD);
        // R6 pair visible only after stop
        wbuf[11] = 8'h41; wbuf[12] = 8'h42;
        write_txn(13, 8'h00, 8'h00, 0);
        chk(regv(11) == 8'h31, "R6 held before stop", regv(11), 8'h31);
        do_stop();
        chk(regv(11) == 8'h41 && regv(12) == 8'h42, "R6 commit at stop", regv(11), 8'h41);
        model[11] = 8'h41; model[12] = 8'h42;

        // R1 foreign address ignored
        do_start();
        put_byte(8'hA4, 0, "R1 foreign address nacked");
        put_byte(8'h00, 0, "R1 skip header");
        put_byte(8'h00, 0, "R1 skip header");
        put_byte(8'h99, 0, "R1 skip data");
        do_stop();
        chk(regv(0) == 8'h11, "R1 no write after foreign address", regv(0), 8'h11);

        // R4 read: count then registers; R10 saturation; R12 nack
        do_start();
        put_byte(8'hD3, 1, "R1 read address");
        get_byte(8'h15, 1, "R4 count byte");
        for (int i = 0; i < NR; i++)
            get_byte(model[i], 1, $sformatf("R4 read reg%0d", i));
        get_byte(model[NR-1], 1, "R10 read saturates");
        get_byte(model[NR-1], 0, "R10 read saturates");
        get_byte(8'hFF, 1, "R12 after host nack");
        do_stop();
        tx_req = 1; @(negedge clk); tx_req = 0;
        chk(tx_valid_o && tx_byte_o == 8'hFF, "R12 request while idle", tx_byte_o, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule